// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block is a bus-attached general-purpose parallel interface. A host reaches it over an 8-bit data bus with an active-low select, separate active-low read and write strobes and a 2-bit register address. Behind the bus are three 8-bit ports and a control register. Each port, and each half of the third port, can be set to drive its pins or to sense them.

Every pin group is modelled as three separate vectors: an input from the pad, an output value and an output enable. The data bus works the same way, with a separate read-data vector and its own enable. The block samples the strobes on the rising clock edge, so a write lands at the first edge seen while the write condition holds. Read data is combinational from the current state for as long as the read condition holds.

Port A holds its input in a register, so a host read returns a steady value. Ports B and C return the live pad values. Port C is split into two 4-bit halves, and each half has its own direction. The block has no stream interfaces, so every pin is a plain level signal.

Top module: `tri_port_pio`

## Requirements
- R1: The address selects the target for both reads and writes: 2'b00 is port A, 2'b01 is port B, 2'b10 is port C and 2'b11 is the control register.
- R2: `dout_oe` is high only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. It is low whenever `cs_n` is high or both strobes are high. While it is high, `dout` carries the selected register.
- R3: A rising clock edge with `cs_n`=0, `wr_n`=0 and `rd_n`=1 loads `din` into the selected output latch or into the control register. An edge with `cs_n` high, or with both strobes low, changes nothing.
- R4: While `rst` is high, the control register takes the value 8'h1B, which sets every direction field to input. All port enables go low and all output latches clear to zero.
- R5: Control bit 4 sets the direction of port A, bit 1 of port B, bit 3 of the upper half of port C and bit 0 of the lower half of port C. A 1 means input and a 0 means output. A port set to output has every bit of its enable high.
- R6: While port A is an input and no read of port A is in progress, its input register captures `pa_in` at every clock edge. During a read of port A it holds its value, even when the read lasts several cycles.
- R7: A read of port B or port C set to input returns the current pad value, with no register in the path.
- R8: The two halves of port C follow their own direction bits. A read of port C with mixed directions returns the pads on the input half and the output latch on the output half. A write to port C loads both 4-bit latches.
- R9: A read of a port set to output returns that port's output latch.
- R10: Any write to the control register clears all three output latches to zero.
- R11: A read of the control register returns the last byte written to it, or 8'h1B after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Data bus drive enable |
| pa_in | input | 8 | Port A pad input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pad enables |
| pb_in | input | 8 | Port B pad input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pad enables |
| pc_in | input | 8 | Port C pad input |
| pc_out | output | 8 | Port C output latches (upper half, lower half) |
| pc_oe | output | 8 | Port C pad enables per half |

## Verification
Two functions can fall in the same cycle: the port A input register tracking its pads, and a host read of port A. The bench holds a port A read for three cycles and changes `pa_in` after the first of them. Every cycle of that read must return the value captured before the read began. A read issued after the strobe is released must show the new pad value. A second overlap is a control write and the output latches: a control write made while the latches hold data must leave all three at zero on the next cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  localparam int DIR_A_BIT   = 4;
  localparam int DIR_B_BIT   = 1;
  localparam int DIR_CHI_BIT = 3;
  localparam int DIR_CLO_BIT = 0;

  localparam logic [PORT_W-1:0] CTL_RESET =
    PORT_W'((1 << DIR_A_BIT) | (1 << DIR_B_BIT) | (1 << DIR_CHI_BIT) | (1 << DIR_CLO_BIT));
endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
  import pio_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  output logic       rd_act,
  output logic [3:0] rd_sel,
  output logic [3:0] wr_sel
);
  logic wr_act;

  assign rd_act = !cs_n && !rd_n && wr_n;
  assign wr_act = !cs_n && !wr_n && rd_n;

  for (genvar i = 0; i < 4; i++) begin : g_sel
    assign rd_sel[i] = rd_act && (addr == 2'(i));
    assign wr_sel[i] = wr_act && (addr == 2'(i));
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        wr_sel,
  input  logic              rd_a,
  input  logic [PORT_W-1:0] din,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] ctrl,
  output logic [PORT_W-1:0] a_out,
  output logic [PORT_W-1:0] b_out,
  output logic [PORT_W-1:0] c_out,
  output logic [PORT_W-1:0] a_lat
);
  logic ctl_wr;
  logic a_cap_en;

  assign ctl_wr   = wr_sel[SEL_CTL];
  assign a_cap_en = ctrl[DIR_A_BIT] && !rd_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTL_RESET;
    end else if (ctl_wr) begin
      ctrl <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_wr) begin
      a_out <= '0;
      b_out <= '0;
    end else begin
      if (wr_sel[SEL_A]) a_out <= din;
      if (wr_sel[SEL_B]) b_out <= din;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_cnib
    logic [HALF_W-1:0] nib_q;
    always_ff @(posedge clk) begin
      if (rst || ctl_wr) begin
        nib_q <= '0;
      end else if (wr_sel[SEL_C]) begin
        nib_q <= din[h*HALF_W +: HALF_W];
      end
    end
    assign c_out[h*HALF_W +: HALF_W] = nib_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_lat <= '0;
    end else if (a_cap_en) begin
      a_lat <= pa_in;
    end
  end

  AST_CTL_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_sel[SEL_CTL] |=> (a_out == '0 && b_out == '0 && c_out == '0)); // R10
  AST_PA_HOLD_ON_READ: assert property (@(posedge clk) disable iff (rst)
    rd_a |=> $stable(a_lat)); // R6
  AST_PB_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_sel[SEL_B] |=> (b_out == $past(din))); // R3
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
(
  input  logic [1:0]        addr,
  input  logic              rd_act,
  input  logic [PORT_W-1:0] ctrl,
  input  logic [PORT_W-1:0] a_lat,
  input  logic [PORT_W-1:0] a_out,
  input  logic [PORT_W-1:0] b_out,
  input  logic [PORT_W-1:0] c_out,
  input  logic [PORT_W-1:0] pb_in,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] dout
);
  logic [PORT_W-1:0] a_view, b_view, c_view, sel_view;
  logic [1:0]        c_dir;

  assign c_dir  = {ctrl[DIR_CHI_BIT], ctrl[DIR_CLO_BIT]};
  assign a_view = ctrl[DIR_A_BIT] ? a_lat : a_out;
  assign b_view = ctrl[DIR_B_BIT] ? pb_in : b_out;

  for (genvar h = 0; h < 2; h++) begin : g_cview
    assign c_view[h*HALF_W +: HALF_W] =
      c_dir[h] ? pc_in[h*HALF_W +: HALF_W] : c_out[h*HALF_W +: HALF_W];
  end

  always_comb begin
    unique case (sel_e'(addr))
      SEL_A:   sel_view = a_view;
      SEL_B:   sel_view = b_view;
      SEL_C:   sel_view = c_view;
      default: sel_view = ctrl;
    endcase
  end

  assign dout = rd_act ? sel_view : '0;
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout,
  output logic              dout_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  logic              rd_act;
  logic [3:0]        rd_sel, wr_sel;
  logic [PORT_W-1:0] ctrl, a_lat;
  logic [1:0]        c_dir;

  pio_bus_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .rd_act(rd_act), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  pio_regs u_regs (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .rd_a(rd_sel[SEL_A]),
    .din(din), .pa_in(pa_in), .ctrl(ctrl), .a_out(pa_out),
    .b_out(pb_out), .c_out(pc_out), .a_lat(a_lat)
  );

  pio_rd_mux u_mux (
    .addr(addr), .rd_act(rd_act), .ctrl(ctrl), .a_lat(a_lat),
    .a_out(pa_out), .b_out(pb_out), .c_out(pc_out),
    .pb_in(pb_in), .pc_in(pc_in), .dout(dout)
  );

  assign dout_oe = rd_act;
  assign pa_oe   = {PORT_W{!ctrl[DIR_A_BIT]}};
  assign pb_oe   = {PORT_W{!ctrl[DIR_B_BIT]}};
  assign c_dir   = {ctrl[DIR_CHI_BIT], ctrl[DIR_CLO_BIT]};

  for (genvar h = 0; h < 2; h++) begin : g_coe
    assign pc_oe[h*HALF_W +: HALF_W] = {HALF_W{!c_dir[h]}};
  end

  AST_OE_OFF_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !dout_oe); // R2
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rd_n && wr_n) |-> !dout_oe); // R2
  AST_RESET_ALL_INPUT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0)); // R4
endmodule

// File: tb/tb_tri_port_pio.sv
module tb_tri_port_pio;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] din = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       dout_oe;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #(CLK_NS/2) clk = ~clk;

  tri_port_pio dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: every cycle with a valid read pops one expected item
  always @(negedge clk) begin
    if (!rst && !cs_n && !rd_n && wr_n) begin
      chk({7'd0, dout_oe}, 8'd1, "R2 oe during read");
      if (expq.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: unexpected read actual=%h expected=none", dout);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(dout, e.v, e.tag);
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.v = e; it.tag = tag;
    expq.push_back(it);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_t it;
    pb_in = 8'h5A;
    repeat (3) @(posedge clk);
    #1;
    // R4: reset state
    chk(pa_oe, 8'h00, "R4 pa_oe in reset");
    chk(pb_oe, 8'h00, "R4 pb_oe in reset");
    chk(pc_oe, 8'h00, "R4 pc_oe in reset");
    chk(pa_out, 8'h00, "R4 pa_out in reset");
    chk({7'd0, dout_oe}, 8'd0, "R4 dout_oe in reset");
    rst = 1'b0;
    @(posedge clk); #1;

    bus_read(2'b11, 8'h1B, "R11 control after reset");
    bus_read(2'b01, 8'h5A, "R7 port B live pins");
    pb_in = 8'hC4; #1;
    bus_read(2'b01, 8'hC4, "R7 port B follows pins");

    // R5: all ports to output
    bus_write(2'b11, 8'h00);
    chk(pa_oe, 8'hFF, "R5 pa_oe output");
    chk(pb_oe, 8'hFF, "R5 pb_oe output");
    chk(pc_oe, 8'hFF, "R5 pc_oe output");
    bus_read(2'b11, 8'h00, "R11 control read back");

    // R1, R3: writes reach the addressed latch
    bus_write(2'b00, 8'h11);
    bus_write(2'b01, 8'h22);
    bus_write(2'b10, 8'h33);
    chk(pa_out, 8'h11, "R1 R3 port A latch");
    chk(pb_out, 8'h22, "R1 R3 port B latch");
    chk(pc_out, 8'h33, "R1 R3 port C latch");
    bus_read(2'b00, 8'h11, "R9 port A output read");
    bus_read(2'b01, 8'h22, "R9 port B output read");
    bus_read(2'b10, 8'h33, "R9 port C output read");

    // R3: ignored writes
    addr = 2'b01; din = 8'h99; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk({7'd0, dout_oe}, 8'd0, "R2 oe off with both strobes low");
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    chk(pb_out, 8'h22, "R3 both strobes low ignored");
    addr = 2'b01; din = 8'h77; cs_n = 1'b1; wr_n = 1'b0;
    @(posedge clk); #1;
    wr_n = 1'b1;
    chk(pb_out, 8'h22, "R3 write without select ignored");
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk({7'd0, dout_oe}, 8'd0, "R2 oe off without select");
    rd_n = 1'b1;
    @(posedge clk); #1;

    // R10: control write clears latches
    bus_write(2'b11, 8'h00);
    chk(pa_out, 8'h00, "R10 port A cleared");
    chk(pb_out, 8'h00, "R10 port B cleared");
    chk(pc_out, 8'h00, "R10 port C cleared");

    // R8: A input, B output, C upper input, C lower output
    bus_write(2'b11, 8'h18);
    chk(pa_oe, 8'h00, "R5 port A input");
    chk(pc_oe, 8'h0F, "R8 port C split enables");
    bus_write(2'b10, 8'hAB);
    chk(pc_out, 8'hAB, "R8 both nibble latches");
    pc_in = 8'h5C; #1;
    bus_read(2'b10, 8'h5B, "R8 mixed port C read");

    // R6: port A input register
    pa_in = 8'h3C;
    @(posedge clk); #1;
    bus_read(2'b00, 8'h3C, "R6 port A captured");
    for (int k = 0; k < 3; k++) begin
      it.v = 8'h3C; it.tag = "R6 port A held during read";
      expq.push_back(it);
    end
    addr = 2'b00; cs_n = 1'b0; rd_n = 1'b0;
    @(posedge clk); #1;
    pa_in = 8'hC3;
    @(posedge clk); #1;
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
    @(posedge clk); #1;
    bus_read(2'b00, 8'hC3, "R6 port A recaptures after read");

    @(posedge clk); #1;
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R2: actual=%0d pending reads expected=0", expq.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule